// File: doc/BRIEF.md
# Snooped Cache-Line Copy-Back Buffer

This block is a one-line staging buffer in a bridge between a host processor bus and system memory. It takes in a 32-byte modified line in a single cycle. The line may be evicted from the processor's L1 or an external L2, whether by a snoop copy-back, an L2 cast-out or an L2 flush. It may also be a processor burst write that must wait while ECC check bits are produced. The buffer then writes the line to memory as four 64-bit beats. It asks for the memory bus with a request/grant handshake and moves one beat on each granted cycle. When a snoop copy-back is caused by a PCI read, the block also strobes a separate PCI-read buffer, so both capture the same line in the same cycle.

While the line waits, every system-memory access is presented on a snoop port and compared against the line-aligned address. The response depends on who made the access. A processor burst write to the same line makes the buffered copy stale, so the buffer drops it and cancels the rest of the drain. A PCI access to the line leaves the buffer untouched and requests a snoop broadcast on the processor bus, but only when snooping is enabled. The processor may hold a newer copy of that line.

Top module: `cbb_copyback_buf`

## Requirements
- R1: After reset, `fill_busy`, `mem_req`, `mem_last`, `snp_inval` and `snp_bcast` are all low.
- R2: A fill presented while `fill_busy` is low is accepted. `fill_busy` is high from the next cycle. For every source other than 3, `mem_req` is also high from the next cycle.
- R3: A fill presented while `fill_busy` is high is refused. The line already held is drained unchanged, and `pcirb_load` stays low for the refused fill.
- R4: The drain sends beat i (i = 0..3) with `mem_wdata` = line bits [64*i+63 : 64*i] and `mem_addr` = line base + 8*i. `mem_last` is high only on beat 3. A beat advances only in a cycle where `mem_req` and `mem_gnt` are both high. `fill_busy` is low in the cycle after beat 3 is granted.
- R5: A fill with `fill_src` = 3 (ECC burst write) keeps `mem_req` low until `ecc_ready` is seen high. `mem_req` rises in the cycle after that.
- R6: `pcirb_load` is high in the same cycle as an accepted fill with `fill_src` = 0 (snoop copy-back for a PCI read). It is low for sources 1 (L2 cast-out), 2 (L2 flush) and 3.
- R7: A snoop hits when the buffer is valid and `snp_addr` equals the line address with bits [4:0] ignored. An address in a different 32-byte line never hits.
- R8: A processor (`snp_is_pci` = 0) burst write (`snp_burst_wr` = 1) that hits raises `snp_inval` for one cycle, in the cycle after the snoop. In that same cycle `fill_busy` and `mem_req` are low, and no further beats are sent.
- R9: A PCI (`snp_is_pci` = 1) hit with `snoop_en` = 1 raises `snp_bcast` for one cycle, in the cycle after the snoop. The buffered line and its drain are unaffected.
- R10: A PCI hit with `snoop_en` = 0 raises no broadcast. A processor access with `snp_burst_wr` = 0 that hits changes nothing and raises neither output.
- R11: If an invalidating hit comes in the same cycle as the grant of beat 3, the drain completes and `snp_inval` stays low.
- R12: While the buffer is empty, no snoop raises `snp_inval` or `snp_bcast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fill_valid | input | 1 | Fill request for a whole line |
| fill_src | input | 2 | Fill source: 0 PCI-read copy-back, 1 L2 cast-out, 2 L2 flush, 3 ECC burst write |
| fill_addr | input | 32 | Address of the line to capture |
| fill_line | input | 256 | Line data, beat 0 in bits [63:0] |
| fill_busy | output | 1 | Buffer holds a line; fills are refused |
| pcirb_load | output | 1 | Load strobe for the PCI-read buffer |
| ecc_ready | input | 1 | ECC check bits are ready for the held burst |
| mem_req | output | 1 | Request to write the line to memory |
| mem_gnt | input | 1 | Memory accepts the current beat |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_wdata | output | 64 | Data of the current beat |
| mem_last | output | 1 | Current beat is the last of the line |
| snp_valid | input | 1 | A system-memory access is presented for compare |
| snp_addr | input | 32 | Address of that access |
| snp_is_pci | input | 1 | Access comes from a PCI agent |
| snp_burst_wr | input | 1 | Processor access is a burst write |
| snoop_en | input | 1 | Processor-bus snooping is enabled |
| snp_inval | output | 1 | Buffer dropped its line after a burst-write hit |
| snp_bcast | output | 1 | Request for a snoop broadcast on the processor bus |

## Verification
Each result has a fixed latency, and the bench samples each one in exactly that cycle, at the falling edge. `pcirb_load` is combinational with the fill and is read while the fill is still driven. `fill_busy` and `mem_req` are read one cycle after the fill edge, or one cycle after `ecc_ready` for an ECC burst. `snp_inval` and `snp_bcast` are registered and are read one cycle after the snoop. Drain beats are checked on every granted cycle against slices of the line the bench generated, under random grant stalls. `fill_busy` is checked low in the cycle after the last grant.

// File: rtl/cbb_pkg.sv
package cbb_pkg;

  // Origin of a line captured by the buffer; the encoding is visible on fill_src.
  typedef enum logic [1:0] {
    SRC_PCI_COPYBACK = 2'd0,
    SRC_L2_CASTOUT   = 2'd1,
    SRC_L2_FLUSH     = 2'd2,
    SRC_ECC_BURST    = 2'd3
  } fill_src_e;

  // Byte-offset mask of a line of the given size in bytes.
  function automatic logic [63:0] line_off_mask(input int unsigned line_bytes);
    return 64'(line_bytes) - 64'd1;
  endfunction

endpackage

// File: rtl/cbb_rst_sync.sv
module cbb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cbb_line_store.sv
module cbb_line_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LINE_W-1:0] load_line,
  input  logic              load_ecc,
  input  logic              ecc_ready,
  input  logic              clear,
  output logic              valid,
  output logic [ADDR_W-1:0] line_addr,
  output logic [LINE_W-1:0] line_data,
  output logic              ecc_hold
);

  logic valid_q, valid_d;
  logic hold_q, hold_d;
  logic ctl_en;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;

  // Next-state: clear (drain done or invalidated) wins over a load.
  always_comb begin
    valid_d = valid_q;
    hold_d  = hold_q;
    if (clear) begin
      valid_d = 1'b0;
      hold_d  = 1'b0;
    end else if (load) begin
      valid_d = 1'b1;
      hold_d  = load_ecc;
    end else if (ecc_ready) begin
      hold_d  = 1'b0;
    end
  end

  assign ctl_en = clear | load | ecc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (ctl_en) begin
      valid_q <= valid_d;
      hold_q  <= hold_d;
    end
  end

  // Payload registers carry no reset; they are qualified by valid_q.
  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= load_addr;
      data_q <= load_line;
    end
  end

  assign valid     = valid_q;
  assign ecc_hold  = hold_q;
  assign line_addr = addr_q;
  assign line_data = data_q;

  // R3: a held line is never overwritten while it stays valid.
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clear) |=> (valid_q && $stable(data_q) && $stable(addr_q)));

  // R5: the ECC hold only exists on an occupied buffer.
  a_r5_hold_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> valid_q);

endmodule

// File: rtl/cbb_drain_seq.sv
module cbb_drain_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_W = 64,
  parameter int unsigned BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic                    ecc_hold,
  input  logic                    cancel,
  input  logic [ADDR_W-1:0]       line_addr,
  input  logic [BEAT_W*BEATS-1:0] line_data,
  input  logic                    mem_gnt,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [BEAT_W-1:0]       mem_wdata,
  output logic                    mem_last,
  output logic                    done
);

  localparam int unsigned BIDX_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int unsigned BEAT_B    = BEAT_W / 8;
  localparam int unsigned BYTE_W    = $clog2(BEAT_B);
  localparam int unsigned LINE_B    = BEAT_B * BEATS;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(cbb_pkg::line_off_mask(LINE_B));
  localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(BEATS - 1);

  logic [BIDX_W-1:0] beat_q, beat_d;
  logic              beat_en;
  logic              take;
  logic [BEAT_W-1:0] words [BEATS];

  // Split the line into beats; beat 0 is the least significant slice.
  for (genvar g = 0; g < BEATS; g++) begin : g_word
    assign words[g] = line_data[g*BEAT_W +: BEAT_W];
  end

  assign mem_req   = valid & ~ecc_hold;
  assign take      = mem_req & mem_gnt;
  assign mem_last  = mem_req & (beat_q == LAST_IDX);
  assign done      = take & (beat_q == LAST_IDX);
  assign mem_wdata = words[beat_q];
  assign mem_addr  = (line_addr & ~OFF_MASK) | (ADDR_W'(beat_q) << BYTE_W);

  always_comb begin
    beat_d = beat_q;
    if (cancel || done) begin
      beat_d = '0;
    end else if (take) begin
      beat_d = beat_q + 1'b1;
    end
  end

  assign beat_en = cancel | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  // R4: a stalled beat holds its address until granted.
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !cancel) |=> (mem_req && $stable(mem_addr)));

  // R4: granted beats walk upward through the line one beat at a time.
  a_r4_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mem_last && !cancel) |=> (mem_addr == $past(mem_addr) + ADDR_W'(BEAT_B)));

  // R4: a drain always starts at beat 0.
  a_r4_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid) |-> (beat_q == '0));

endmodule

// File: rtl/cbb_snoop_cmp.sv
module cbb_snoop_cmp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_B = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_is_pci,
  input  logic              snp_burst_wr,
  input  logic              snoop_en,
  input  logic              drain_done,
  output logic              inv_hit,
  output logic              inval,
  output logic              bcast
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(cbb_pkg::line_off_mask(LINE_B));

  logic hit;
  logic inval_q, inval_d;
  logic bcast_q, bcast_d;

  assign hit     = snp_valid & valid & (((snp_addr ^ line_addr) & ~OFF_MASK) == '0);
  assign inv_hit = hit & ~snp_is_pci & snp_burst_wr;

  always_comb begin
    inval_d = inv_hit & ~drain_done;
    bcast_d = hit & snp_is_pci & snoop_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inval_q <= 1'b0;
      bcast_q <= 1'b0;
    end else begin
      inval_q <= inval_d;
      bcast_q <= bcast_d;
    end
  end

  assign inval = inval_q;
  assign bcast = bcast_q;

  // R12: an empty buffer answers no snoop.
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid) |=> (!inval_q && !bcast_q));

  // R10: no broadcast is requested while snooping is disabled.
  a_r10_no_bcast_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!snoop_en) |=> !bcast_q);

  // R8 and R9: one access cannot both invalidate and broadcast.
  a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(inval_q && bcast_q));

endmodule

// File: rtl/cbb_copyback_buf.sv
module cbb_copyback_buf #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_W = 64,
  parameter int unsigned BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_valid,
  input  logic [1:0]              fill_src,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [BEAT_W*BEATS-1:0] fill_line,
  output logic                    fill_busy,
  output logic                    pcirb_load,
  input  logic                    ecc_ready,
  output logic                    mem_req,
  input  logic                    mem_gnt,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [BEAT_W-1:0]       mem_wdata,
  output logic                    mem_last,
  input  logic                    snp_valid,
  input  logic [ADDR_W-1:0]       snp_addr,
  input  logic                    snp_is_pci,
  input  logic                    snp_burst_wr,
  input  logic                    snoop_en,
  output logic                    snp_inval,
  output logic                    snp_bcast
);

  import cbb_pkg::*;

  localparam int unsigned LINE_W = BEAT_W * BEATS;
  localparam int unsigned LINE_B = LINE_W / 8;

  logic              rst_sync_n;
  logic              valid;
  logic              ecc_hold;
  logic              load;
  logic              clear;
  logic              drain_done;
  logic              inv_hit;
  fill_src_e         src;
  logic [ADDR_W-1:0] line_addr;
  logic [LINE_W-1:0] line_data;

  cbb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign src        = fill_src_e'(fill_src);
  assign load       = fill_valid & ~valid;
  assign clear      = drain_done | inv_hit;
  assign fill_busy  = valid;
  assign pcirb_load = load & (src == SRC_PCI_COPYBACK);

  cbb_line_store #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .load_addr (fill_addr),
    .load_line (fill_line),
    .load_ecc  (src == SRC_ECC_BURST),
    .ecc_ready (ecc_ready),
    .clear     (clear),
    .valid     (valid),
    .line_addr (line_addr),
    .line_data (line_data),
    .ecc_hold  (ecc_hold)
  );

  cbb_drain_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_drain (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .valid     (valid),
    .ecc_hold  (ecc_hold),
    .cancel    (inv_hit),
    .line_addr (line_addr),
    .line_data (line_data),
    .mem_gnt   (mem_gnt),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_last  (mem_last),
    .done      (drain_done)
  );

  cbb_snoop_cmp #(.ADDR_W(ADDR_W), .LINE_B(LINE_B)) u_snoop (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .valid        (valid),
    .line_addr    (line_addr),
    .snp_valid    (snp_valid),
    .snp_addr     (snp_addr),
    .snp_is_pci   (snp_is_pci),
    .snp_burst_wr (snp_burst_wr),
    .snoop_en     (snoop_en),
    .drain_done   (drain_done),
    .inv_hit      (inv_hit),
    .inval        (snp_inval),
    .bcast        (snp_bcast)
  );

  // R2: an accepted fill occupies the buffer on the next cycle.
  a_r2_fill_takes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fill_valid && !fill_busy) |=> fill_busy);

  // R4: the buffer empties right after the last beat is granted.
  a_r4_last_empties: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && mem_gnt && mem_last) |=> !fill_busy);

  // R8: a reported invalidation leaves nothing to drain.
  a_r8_inval_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snp_inval |-> (!fill_busy && !mem_req));

  // R11: a completing drain is never reported as invalidated.
  a_r11_last_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && mem_gnt && mem_last) |=> !snp_inval);

  // R1: nothing is requested or reported while reset is held internally.
  a_r1_reset_quiet: assert property (@(posedge clk)
    (!rst_sync_n) |-> (!mem_req && !fill_busy && !snp_inval && !snp_bcast));

endmodule

// File: tb/cbb_copyback_buf_bench.sv
module cbb_copyback_buf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         fill_valid;
  logic [1:0]   fill_src;
  logic [31:0]  fill_addr;
  logic [255:0] fill_line;
  logic         fill_busy;
  logic         pcirb_load;
  logic         ecc_ready;
  logic         mem_req;
  logic         mem_gnt;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic         mem_last;
  logic         snp_valid;
  logic [31:0]  snp_addr;
  logic         snp_is_pci;
  logic         snp_burst_wr;
  logic         snoop_en;
  logic         snp_inval;
  logic         snp_bcast;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbb_copyback_buf u_cbb_copyback_buf (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_src(fill_src), .fill_addr(fill_addr),
    .fill_line(fill_line), .fill_busy(fill_busy), .pcirb_load(pcirb_load),
    .ecc_ready(ecc_ready), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_last(mem_last),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_is_pci(snp_is_pci),
    .snp_burst_wr(snp_burst_wr), .snoop_en(snoop_en),
    .snp_inval(snp_inval), .snp_bcast(snp_bcast)
  );

  // Reference values derived from the requirements.
  function automatic logic [63:0] exp_beat(input logic [255:0] line, input int i);
    return line[i*64 +: 64];
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int i);
    return {base[31:5], 5'b0} + 32'(i * 8);
  endfunction

  function automatic logic same_line(input logic [31:0] a, input logic [31:0] b);
    return a[31:5] == b[31:5];
  endfunction

  function automatic logic [255:0] rand_line();
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = $urandom;
    return l;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_fill(input logic [1:0] src, input logic [31:0] a,
                         input logic [255:0] l, input logic exp_pcirb);
    fill_valid = 1'b1; fill_src = src; fill_addr = a; fill_line = l;
    #1;
    check("R6 pcirb_load", 64'(pcirb_load), 64'(exp_pcirb));
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_snoop(input logic [31:0] a, input logic pci, input logic bw,
                          input logic en, input logic exp_inv, input logic exp_bc,
                          input string tag);
    snp_valid = 1'b1; snp_addr = a; snp_is_pci = pci; snp_burst_wr = bw; snoop_en = en;
    @(negedge clk);
    snp_valid = 1'b0;
    check({tag, " snp_inval"}, 64'(snp_inval), 64'(exp_inv));
    check({tag, " snp_bcast"}, 64'(snp_bcast), 64'(exp_bc));
  endtask

  task automatic drain(input logic [31:0] base, input logic [255:0] l, input bit stalls);
    int i = 0;
    int waits = 0;
    while (i < 4) begin
      check("R4 mem_req during drain", 64'(mem_req), 64'd1);
      if (stalls && waits < 3 && ($urandom % 3 == 0)) begin
        mem_gnt = 1'b0;
        waits++;
      end else begin
        mem_gnt = 1'b1;
        waits = 0;
        check("R4 mem_addr", 64'(mem_addr), 64'(exp_addr(base, i)));
        check("R4 mem_wdata", mem_wdata, exp_beat(l, i));
        check("R4 mem_last", 64'(mem_last), 64'(i == 3));
      end
      @(negedge clk);
      if (mem_gnt) i++;
    end
    mem_gnt = 1'b0;
    check("R4 busy clears after last beat", 64'(fill_busy), 64'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [255:0] la, lb;
    logic [31:0]  aa, ab;
    void'($urandom(32'd1234));
    rst_n = 1'b0; fill_valid = 1'b0; fill_src = 2'd0; fill_addr = '0; fill_line = '0;
    ecc_ready = 1'b0; mem_gnt = 1'b0; snp_valid = 1'b0; snp_addr = '0;
    snp_is_pci = 1'b0; snp_burst_wr = 1'b0; snoop_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 64'(fill_busy), 64'd0);
    check("R1 req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy", 64'(fill_busy), 64'd0);
    check("R1 mem_req", 64'(mem_req), 64'd0);
    check("R1 mem_last", 64'(mem_last), 64'd0);
    check("R1 snp_inval", 64'(snp_inval), 64'd0);
    check("R1 snp_bcast", 64'(snp_bcast), 64'd0);

    // R12: snoops on an empty buffer.
    do_snoop(32'h1000_0040, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R12 idle burst wr");
    do_snoop(32'h1000_0040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R12 idle pci");

    // R2, R6, R3: fill, refused second fill, drain of the first line.
    la = rand_line(); aa = 32'h1000_0040;
    lb = rand_line(); ab = 32'h2000_0080;
    do_fill(2'd0, aa, la, 1'b1);
    check("R2 busy after fill", 64'(fill_busy), 64'd1);
    check("R2 req after fill", 64'(mem_req), 64'd1);
    do_fill(2'd0, ab, lb, 1'b0);
    check("R3 busy kept", 64'(fill_busy), 64'd1);

    // R7, R9, R10 on the held line, then R3/R9 data intact.
    do_snoop(32'h1000_005C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7 R9 pci hit low bits");
    do_snoop(32'h1000_0060, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 next line miss");
    do_snoop(32'h1000_0048, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 pci hit snoop off");
    do_snoop(32'h1000_0040, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 proc single hit");
    do_snoop(32'h3000_0040, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 proc burst miss");
    check("R10 busy unchanged", 64'(fill_busy), 64'd1);
    drain(aa, la, 1'b1);

    // R6: other sources do not strobe the PCI-read buffer.
    do_fill(2'd1, ab, lb, 1'b0);
    drain(ab, lb, 1'b0);
    do_fill(2'd2, aa, la, 1'b0);
    drain(aa, la, 1'b1);

    // R5: ECC burst waits for ecc_ready.
    do_fill(2'd3, ab, lb, 1'b0);
    for (int k = 0; k < 4; k++) begin
      check("R5 req held during ECC", 64'(mem_req), 64'd0);
      @(negedge clk);
    end
    ecc_ready = 1'b1;
    check("R5 req before ecc edge", 64'(mem_req), 64'd0);
    @(negedge clk);
    ecc_ready = 1'b0;
    check("R5 req after ecc_ready", 64'(mem_req), 64'd1);
    drain(ab, lb, 1'b0);

    // R8: invalidate mid-drain after one beat.
    do_fill(2'd1, aa, la, 1'b0);
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    do_snoop(32'h1000_0050, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8 burst wr hit");
    check("R8 busy after inval", 64'(fill_busy), 64'd0);
    check("R8 req after inval", 64'(mem_req), 64'd0);
    @(negedge clk);
    check("R8 inval is a pulse", 64'(snp_inval), 64'd0);

    // R11: hit in the cycle of the last beat grant.
    do_fill(2'd2, ab, lb, 1'b0);
    mem_gnt = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 last beat", 64'(mem_last), 64'd1);
    check("R11 last data", mem_wdata, exp_beat(lb, 3));
    do_snoop(ab, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R11 hit on last beat");
    mem_gnt = 1'b0;
    check("R11 busy cleared", 64'(fill_busy), 64'd0);

    // Random mix of fills, snoops and stalled drains.
    for (int it = 0; it < 40; it++) begin
      logic [1:0]  src;
      logic [31:0] a, sa;
      logic        pci, bw, en, hit, ei, eb;
      int          kind;
      src = 2'($urandom % 3);
      a = $urandom; la = rand_line();
      do_fill(src, a, la, src == 2'd0);
      check("R2 busy random fill", 64'(fill_busy), 64'd1);
      kind = $urandom % 4;
      hit = ($urandom % 2) == 1;
      sa = hit ? {a[31:5], 5'($urandom)} : {a[31:5] ^ 27'd1, 5'($urandom)};
      pci = (kind < 2); en = (kind == 0); bw = (kind == 2);
      ei = hit && !pci && bw && same_line(sa, a);
      eb = hit && pci && en && same_line(sa, a);
      do_snoop(sa, pci, bw, en, ei, eb, ei ? "R8 random" : "R9 R10 random");
      if (ei) check("R8 random busy", 64'(fill_busy), 64'd0);
      else drain(a, la, 1'b1);
    end

    summary();
    $finish;
  end

endmodule